// File: doc/BRIEF.md
# Operand Criticality Predictor

This block guesses, at dispatch time, whether the result of a producing instruction will be needed urgently by its consumers. The guess decides which of two interconnects carries the value: a fast one or a slower, low-power one. The guess comes from a table of saturating counters, indexed by low-order bits of the producer's program counter. The lookup is made when an instruction is sent to its cluster, and the one-bit answer travels with the instruction.

The counters learn from measured slack. For each source operand of an instruction waiting in the issue queue, a slack meter counts the cycles between the operand's arrival and the instruction's execution. When the instruction executes, the meter reports whether that gap reached a threshold. A gap at or above the threshold marks the operand's transfer as latency-insensitive. A shorter gap marks it critical.

At completion, the producer's index bits and the measured bit are presented on the training port, one lane per operand. The addressed counter then moves one step toward critical or toward non-critical.

Top module: `crit_pred_top`

## Requirements
- R1: After reset every counter holds the weakly-critical value 2, so the first lookup of any index predicts critical (pred_crit=1), and pred_valid and meas_done are low.
- R2: A lookup accepted in cycle t raises pred_valid in cycle t+1, with pred_crit equal to bit 1 (the upper bit) of the addressed 2-bit counter. pred_valid is low in any cycle that follows a cycle without a lookup.
- R3: A training sample with trn_crit=1 increments the addressed counter, saturating at 3.
- R4: A training sample with trn_crit=0 decrements the addressed counter, saturating at 0. Non-critical (pred_crit=0) is predicted only when the counter is 0 or 1.
- R5: For an operand lane, let gap be the number of cycles from meas_arrive to meas_issue. In the cycle after meas_issue, meas_done is 1 and meas_noncrit is 1 exactly when gap >= SLACK_THRESH (default 3).
- R6: When meas_arrive and meas_issue are high in the same cycle, the gap is 0 and the operand is reported critical (meas_noncrit=0).
- R7: The slack count saturates instead of wrapping, so a very long wait (40 cycles) is still reported non-critical.
- R8: A lookup and a training sample to the same entry in the same cycle return the counter value from before the update.
- R9: When two training lanes address the same entry in one cycle, the entry moves by a single step, and that step is an increment if either lane is critical.
- R10: Training lanes that address different entries in one cycle all update their entries, and entries at the index extremes (0 and 1023) are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request at dispatch |
| lk_idx | input | 10 | Producer PC bits for the lookup |
| pred_valid | output | 1 | Prediction available, one cycle after the lookup |
| pred_crit | output | 1 | 1 = result predicted critical |
| meas_arrive | input | 2 | Per lane: the operand arrived in the issue queue |
| meas_issue | input | 2 | Per lane: the consuming instruction executes |
| meas_done | output | 2 | Per lane: slack verdict valid |
| meas_noncrit | output | 2 | Per lane: 1 = gap reached the threshold |
| trn_valid | input | 2 | Per lane: training sample present |
| trn_idx | input | 20 | Per lane: producer PC bits, lane p at bits [p*10 +: 10] |
| trn_crit | input | 2 | Per lane: 1 = critical sample |

## Verification
The hardest case to reach from the ports is a collision: both training lanes, or a lookup and a training lane, address the same entry in the same cycle. Each of these cases must differ visibly from the case with no collision. The stimulus first steers the entry to a counter value where a double step, or a lost critical sample, would flip a later prediction. It then drives the colliding cycle and reads the entry back with follow-up lookups. The slack meters are driven with gaps on both sides of the threshold, including a zero gap and a wait long enough to wrap a counter that does not saturate.

// File: rtl/crit_pred_pkg.sv
package crit_pred_pkg;

   typedef enum logic {
      VERDICT_NONCRIT = 1'b0,
      VERDICT_CRIT    = 1'b1
   } verdict_e;

   // one saturating step of an unsigned value bounded by [0, hi]
   function automatic int unsigned sat_step(input int unsigned v,
                                            input int unsigned hi,
                                            input logic        up);
      if (up) return (v >= hi) ? hi : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/crit_slack_meter.sv
module crit_slack_meter
   import crit_pred_pkg::*;
#(
   parameter int unsigned SLACK_THRESH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arrive,
   input  logic issue,
   output logic done,
   output logic noncrit
);
   localparam int unsigned SW = cnt_bits(SLACK_THRESH);

   logic          armed_q;
   logic [SW-1:0] age_q;
   logic [SW-1:0] gap;
   verdict_e      verdict;

   // gap is 0 when the operand arrives in the issue cycle or was never seen
   always_comb begin
      gap     = (armed_q && !arrive) ? age_q : '0;
      verdict = (32'(gap) >= SLACK_THRESH) ? VERDICT_NONCRIT : VERDICT_CRIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         age_q   <= '0;
         done    <= 1'b0;
         noncrit <= 1'b0;
      end else begin
         done    <= issue;
         noncrit <= issue && (verdict == VERDICT_NONCRIT);
         if (issue) begin
            armed_q <= 1'b0;
            age_q   <= '0;
         end else if (arrive) begin
            armed_q <= 1'b1;
            age_q   <= SW'(1);
         end else if (armed_q) begin
            age_q   <= SW'(sat_step(32'(age_q), SLACK_THRESH, 1'b1));
         end
      end
   end
endmodule

// File: rtl/crit_train_merge.sv
module crit_train_merge #(
   parameter int unsigned NUM_OPS = 2,
   parameter int unsigned IDX_W   = 10
) (
   input  logic [NUM_OPS-1:0]       in_valid,
   input  logic [NUM_OPS*IDX_W-1:0] in_idx,
   input  logic [NUM_OPS-1:0]       in_crit,
   output logic [NUM_OPS-1:0]       wr_en,
   output logic [NUM_OPS-1:0]       wr_crit
);
   // lowest lane owns a shared entry; any critical lane on it makes the step upward
   always_comb begin
      for (int p = 0; p < NUM_OPS; p++) begin
         wr_en[p]   = in_valid[p];
         wr_crit[p] = in_valid[p] & in_crit[p];
         for (int q = 0; q < NUM_OPS; q++) begin
            if (in_valid[q] && in_idx[q*IDX_W +: IDX_W] == in_idx[p*IDX_W +: IDX_W]) begin
               if (q < p) wr_en[p] = 1'b0;
               if (in_crit[q]) wr_crit[p] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/crit_ctr_table.sv
module crit_ctr_table
   import crit_pred_pkg::*;
#(
   parameter int unsigned NUM_OPS = 2,
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned CTR_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic                     rd_valid,
   output logic                     rd_crit,
   input  logic [NUM_OPS-1:0]       wr_en,
   input  logic [NUM_OPS*IDX_W-1:0] wr_idx,
   input  logic [NUM_OPS-1:0]       wr_crit
);
   localparam int unsigned ENTRIES  = 1 << IDX_W;
   localparam int unsigned CTR_MAX  = (1 << CTR_W) - 1;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1 << (CTR_W - 1));

   logic [CTR_W-1:0] ctr_q [ENTRIES];

   // read samples the pre-update value at the same edge as any write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_crit  <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_crit <= ctr_q[rd_idx][CTR_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_INIT;
      end else begin
         for (int p = 0; p < NUM_OPS; p++) begin
            if (wr_en[p])
               ctr_q[wr_idx[p*IDX_W +: IDX_W]] <=
                  CTR_W'(sat_step(32'(ctr_q[wr_idx[p*IDX_W +: IDX_W]]), CTR_MAX, wr_crit[p]));
         end
      end
   end
endmodule

// File: rtl/crit_pred_top.sv
module crit_pred_top #(
   parameter int unsigned NUM_OPS      = 2,
   parameter int unsigned IDX_W        = 10,
   parameter int unsigned CTR_W        = 2,
   parameter int unsigned SLACK_THRESH = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [IDX_W-1:0]         lk_idx,
   output logic                     pred_valid,
   output logic                     pred_crit,
   input  logic [NUM_OPS-1:0]       meas_arrive,
   input  logic [NUM_OPS-1:0]       meas_issue,
   output logic [NUM_OPS-1:0]       meas_done,
   output logic [NUM_OPS-1:0]       meas_noncrit,
   input  logic [NUM_OPS-1:0]       trn_valid,
   input  logic [NUM_OPS*IDX_W-1:0] trn_idx,
   input  logic [NUM_OPS-1:0]       trn_crit
);
   if (NUM_OPS < 1 || NUM_OPS > 4) begin : g_bad_ops
      $error("NUM_OPS must be 1..4");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("IDX_W must be 1..12");
   end
   if (CTR_W < 2 || CTR_W > 4) begin : g_bad_ctr
      $error("CTR_W must be 2..4");
   end
   if (SLACK_THRESH < 1) begin : g_bad_thr
      $error("SLACK_THRESH must be at least 1");
   end

   logic [NUM_OPS-1:0] wr_en;
   logic [NUM_OPS-1:0] wr_crit;

   for (genvar p = 0; p < NUM_OPS; p++) begin : g_meter
      crit_slack_meter #(.SLACK_THRESH(SLACK_THRESH)) meter_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .arrive  (meas_arrive[p]),
         .issue   (meas_issue[p]),
         .done    (meas_done[p]),
         .noncrit (meas_noncrit[p])
      );
   end

   crit_train_merge #(.NUM_OPS(NUM_OPS), .IDX_W(IDX_W)) merge_i (
      .in_valid (trn_valid),
      .in_idx   (trn_idx),
      .in_crit  (trn_crit),
      .wr_en    (wr_en),
      .wr_crit  (wr_crit)
   );

   crit_ctr_table #(.NUM_OPS(NUM_OPS), .IDX_W(IDX_W), .CTR_W(CTR_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (lk_valid),
      .rd_idx   (lk_idx),
      .rd_valid (pred_valid),
      .rd_crit  (pred_crit),
      .wr_en    (wr_en),
      .wr_idx   (trn_idx),
      .wr_crit  (wr_crit)
   );
endmodule

// File: rtl/crit_pred_chk.sv
module crit_pred_chk #(
   parameter int unsigned NUM_OPS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               pred_valid,
   input logic [NUM_OPS-1:0] meas_arrive,
   input logic [NUM_OPS-1:0] meas_issue,
   input logic [NUM_OPS-1:0] meas_done,
   input logic [NUM_OPS-1:0] meas_noncrit
);
   // R2
   lookup_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pred_valid);

   // R2
   lookup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pred_valid);

   // R5
   verdict_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_issue != '0) |=> ((meas_done & $past(meas_issue)) == $past(meas_issue)));

   // R5
   verdict_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_noncrit & ~meas_done) == '0);

   // R6
   zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((meas_arrive & meas_issue) != '0) |=> ((meas_noncrit & $past(meas_arrive & meas_issue)) == '0));
endmodule

bind crit_pred_top crit_pred_chk #(.NUM_OPS(NUM_OPS)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .pred_valid   (pred_valid),
   .meas_arrive  (meas_arrive),
   .meas_issue   (meas_issue),
   .meas_done    (meas_done),
   .meas_noncrit (meas_noncrit)
);

// File: tb/crit_pred_top_tb_top.sv
module crit_pred_top_tb_top;
   localparam int NOPS = 2;
   localparam int IW   = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lk_valid = 1'b0;
   logic [IW-1:0]   lk_idx = '0;
   logic            pred_valid, pred_crit;
   logic [NOPS-1:0] meas_arrive = '0, meas_issue = '0;
   logic [NOPS-1:0] meas_done, meas_noncrit;
   logic [NOPS-1:0] trn_valid = '0;
   logic [NOPS*IW-1:0] trn_idx = '0;
   logic [NOPS-1:0] trn_crit = '0;

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   int model [1024];

   bit    pred_q [$];
   string pred_tag [$];
   bit    m0_q [$], m1_q [$];
   string m0_tag [$], m1_tag [$];

   always #2 clk = ~clk;

   crit_pred_top dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_idx(lk_idx),
      .pred_valid(pred_valid), .pred_crit(pred_crit),
      .meas_arrive(meas_arrive), .meas_issue(meas_issue),
      .meas_done(meas_done), .meas_noncrit(meas_noncrit),
      .trn_valid(trn_valid), .trn_idx(trn_idx), .trn_crit(trn_crit)
   );

   function automatic int mstep(int v, bit up);
      if (up) return (v >= 3) ? 3 : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (pred_valid) begin
            if (pred_q.size() == 0) check(0, "R2 unexpected prediction", 1, 0);
            else begin
               automatic bit e = pred_q.pop_front();
               automatic string t = pred_tag.pop_front();
               check(pred_crit == e, t, pred_crit, e);
            end
         end
         if (meas_done[0]) begin
            if (m0_q.size() == 0) check(0, "R5 unexpected verdict lane0", 1, 0);
            else begin
               automatic bit e = m0_q.pop_front();
               automatic string t = m0_tag.pop_front();
               check(meas_noncrit[0] == e, t, meas_noncrit[0], e);
            end
         end
         if (meas_done[1]) begin
            if (m1_q.size() == 0) check(0, "R5 unexpected verdict lane1", 1, 0);
            else begin
               automatic bit e = m1_q.pop_front();
               automatic string t = m1_tag.pop_front();
               check(meas_noncrit[1] == e, t, meas_noncrit[1], e);
            end
         end
      end
   end

   task automatic look(int idx, string tag);
      lk_valid = 1'b1; lk_idx = IW'(idx);
      pred_q.push_back(model[idx] >= 2); pred_tag.push_back(tag);
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic train(bit v0, int i0, bit c0, bit v1, int i1, bit c1,
                        bit wl, int li, string tag);
      trn_valid = {v1, v0};
      trn_idx   = {IW'(i1), IW'(i0)};
      trn_crit  = {c1, c0};
      if (wl) begin
         lk_valid = 1'b1; lk_idx = IW'(li);
         pred_q.push_back(model[li] >= 2); pred_tag.push_back(tag);
      end
      if (v0 && v1 && i0 == i1) model[i0] = mstep(model[i0], c0 | c1);
      else begin
         if (v0) model[i0] = mstep(model[i0], c0);
         if (v1) model[i1] = mstep(model[i1], c1);
      end
      @(negedge clk);
      trn_valid = '0; lk_valid = 1'b0;
   endtask

   task automatic one(int idx, bit c);
      train(1, idx, c, 0, 0, 0, 0, 0, "");
   endtask

   task automatic meas(int op, int k, string tag);
      if (op == 0) begin m0_q.push_back(k >= 3); m0_tag.push_back(tag); end
      else         begin m1_q.push_back(k >= 3); m1_tag.push_back(tag); end
      meas_arrive[op] = 1'b1;
      if (k == 0) meas_issue[op] = 1'b1;
      @(negedge clk);
      meas_arrive[op] = 1'b0;
      if (k == 0) meas_issue[op] = 1'b0;
      else begin
         repeat (k - 1) @(negedge clk);
         meas_issue[op] = 1'b1;
         @(negedge clk);
         meas_issue[op] = 1'b0;
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      foreach (model[i]) model[i] = 2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(pred_valid == 0, "R1 pred_valid after reset", pred_valid, 0);
      check(meas_done == 0, "R1 meas_done after reset", meas_done, 0);
      look(5, "R1 first lookup critical");
      look(1000, "R1 first lookup critical far index");

      // R4 decrement and floor
      one(5, 0); look(5, "R4 one noncrit sample");
      one(5, 0); one(5, 0); one(5, 0);
      one(5, 1); look(5, "R4 floor then one up");
      one(5, 1); look(5, "R4 floor then two up");

      // R3 increment and ceiling
      one(9, 1); one(9, 1); one(9, 1); one(9, 1);
      one(9, 0); look(9, "R3 ceiling then one down");
      one(9, 0); look(9, "R3 ceiling then two down");

      // R8 same-cycle lookup and update
      train(1, 20, 0, 0, 0, 0, 1, 20, "R8 lookup sees old value");
      look(20, "R8 lookup after update");

      // R9 same-entry collision, critical wins
      train(1, 30, 0, 1, 30, 1, 0, 0, "");
      one(30, 0); look(30, "R9 crit wins then one down");
      one(30, 0); look(30, "R9 crit wins then two down");
      train(1, 40, 0, 1, 40, 0, 0, 0, "");
      look(40, "R9 single step on shared entry");
      one(40, 1); look(40, "R9 single step then up");

      // R10 distinct entries and index extremes
      train(1, 50, 0, 1, 51, 0, 0, 0, "");
      look(50, "R10 lane0 entry updated");
      look(51, "R10 lane1 entry updated");
      one(1023, 0);
      look(0, "R10 entry 0 untouched");
      look(1023, "R10 entry 1023 updated");

      // R5 slack thresholds on both lanes
      meas(0, 1, "R5 gap 1 critical");
      meas(0, 2, "R5 gap 2 critical");
      meas(0, 3, "R5 gap 3 noncritical");
      meas(0, 4, "R5 gap 4 noncritical");
      meas(1, 2, "R5 lane1 gap 2 critical");
      meas(1, 3, "R5 lane1 gap 3 noncritical");
      // R6 zero gap
      meas(0, 0, "R6 same-cycle arrive and issue");
      meas(1, 0, "R6 lane1 same-cycle arrive and issue");
      // R7 saturation over a long wait
      meas(0, 40, "R7 long wait stays noncritical");
      meas(1, 33, "R7 lane1 long wait stays noncritical");

      repeat (3) @(negedge clk);
      check(pred_q.size() == 0, "R2 missing predictions", pred_q.size(), 0);
      check(m0_q.size() + m1_q.size() == 0, "R5 missing verdicts",
            m0_q.size() + m1_q.size(), 0);
      finish_up();
   end
endmodule